// File: doc/BRIEF.md
# Serial Receiver Status Flag Controller

This block sits between the bit-level core of an asynchronous serial receiver and the processor that reads it. The core reports each finished word with a one-cycle strobe. Along with the strobe it supplies the word, a noise flag it built up while shifting the word in, and a framing error indication. The core also supplies the sampled line level and a pulse once per bit time. From these inputs the block keeps a receive data register and five status flags: receive-full, idle-line, overrun, noise and framing.

The processor sees the flags through a status byte and the word through a data output. It reads them with separate one-cycle status-read and data-read strobes. Receive-full, idle and overrun are cleared in two steps. First a status read must see the flag set. Then a data read clears that flag.

The idle flag is set when a run of ones on the line reaches the idle length. It sets at most once for each received word, and only after the receiver has been enabled and has taken in a word.

Top module: `rxstat_ctrl`

## Requirements
- R1: After reset, `status_q` and `data_q` are zero.
- R2: When `word_done` is high while `rx_en` is high and neither receive-full nor overrun is set, `data_q` takes `word_data` on that clock edge and receive-full is set on the same edge.
- R3: When `word_done` arrives while receive-full or overrun is set, overrun is set on that edge and `data_q` keeps its old value.
- R4: Every word that arrives while overrun is set is discarded. After the clear sequence, the next word loads normally.
- R5: Receive-full, idle and overrun each clear on the edge of a data read. This happens only if the most recent earlier status read saw that flag set.
- R6: A data read that has no arming status read before it clears nothing. A flag that became set after the arming status read survives the data read.
- R7: The idle flag sets on the bit tick that completes a run of consecutive ones of length 10 when `nine_bit`=0, or 11 when `nine_bit`=1. A zero sampled on a tick restarts the run.
- R8: The idle flag can set only after a word has been loaded since `rx_en` was last high. Once an idle event has occurred, the flag cannot set again until another word is loaded.
- R9: An idle event that occurs while `wake_hold` is high does not set the idle flag. That event still uses up the arming from the last loaded word.
- R10: The noise flag (`noise_work`) and the framing flag (`frame_err`) are captured on the same edge that loads a word and sets receive-full. A discarded word leaves both flags unchanged.
- R11: The `status_q` layout is: bit 5 receive-full, bit 4 idle, bit 3 overrun, bit 2 noise, bit 1 framing. Bits 7, 6 and 0 read as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rx_en | input | 1 | Receiver enabled; while low, idle detection and arming are held clear and words are ignored |
| nine_bit | input | 1 | 1 selects 9-bit framing (idle length 11), 0 selects 8-bit (idle length 10) |
| wake_hold | input | 1 | Receiver is asleep waiting for an idle line; idle events do not set the flag |
| word_done | input | 1 | One-cycle strobe: a shifted word is complete |
| word_data | input | 9 | The completed word |
| noise_work | input | 1 | Working noise flag for the completed word |
| frame_err | input | 1 | Framing error for the completed word |
| line_bit | input | 1 | Sampled serial line level |
| bit_tick | input | 1 | One pulse per bit time |
| stat_rd | input | 1 | Processor status-register read strobe |
| data_rd | input | 1 | Processor data-register read strobe |
| status_q | output | 8 | Status byte |
| data_q | output | 9 | Receive data register |

## Verification
The hardest case to reach is a flag that becomes set between the arming status read and the data read. Reaching it takes a status read while the register is empty, then a word arriving, then the data read, and the flag must survive. A second hard case is the idle run that reaches its length while the receiver is asleep. The bench drives a word, clears it, holds `wake_hold` high through ten ones, then drops it and sends a fresh run of ones. It checks that no idle flag appears in either phase. The overrun path is driven with a second and a third word while the register is full, and each of those words carries noise, to show that the discarded words leave both the noise flag and the data unchanged.

// File: rtl/rxstat_pkg.sv
package rxstat_pkg;

  typedef struct packed {
    logic full;
    logic idle;
    logic ovr;
  } clr_mask_t;

  typedef struct packed {
    logic full;
    logic idle;
    logic ovr;
    logic noise;
    logic frame;
  } rx_flags_t;

  // ones needed for an idle line: start + data + stop, plus one for 9-bit
  function automatic int unsigned idle_ones_needed(int unsigned data_bits, logic nine);
    return data_bits + 2 + (nine ? 1 : 0);
  endfunction

  function automatic logic [7:0] pack_status(rx_flags_t f);
    return {2'b00, f.full, f.idle, f.ovr, f.noise, f.frame, 1'b0};
  endfunction

endpackage

// File: rtl/rxstat_idle_det.sv
module rxstat_idle_det #(
  parameter int unsigned DATA_BITS = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic enable,
  input  logic nine_bit,
  input  logic line_bit,
  input  logic bit_tick,
  output logic idle_evt
);
  import rxstat_pkg::*;

  localparam int unsigned MAX_RUN = DATA_BITS + 3;
  localparam int unsigned CW      = $clog2(MAX_RUN + 1);

  logic [CW-1:0] run_q;
  logic [CW-1:0] run_lim;

  assign run_lim  = CW'(idle_ones_needed(DATA_BITS, nine_bit));
  assign idle_evt = enable && bit_tick && line_bit && (run_q == run_lim - CW'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q <= '0;
    end else if (!enable) begin
      run_q <= '0;
    end else if (bit_tick) begin
      if (!line_bit)             run_q <= '0;
      else if (run_q < run_lim)  run_q <= run_q + CW'(1);
    end
  end

  // a run produces one event, then the counter rests at its limit
  assert_idle_single_event_R7: assert property (@(posedge clk) disable iff (!rst_n)
    idle_evt |=> !idle_evt);

  assert_idle_run_bounded_R7: assert property (@(posedge clk) disable iff (!rst_n)
    run_q <= CW'(MAX_RUN));

endmodule

// File: rtl/rxstat_clr_seq.sv
module rxstat_clr_seq (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  stat_rd,
  input  logic                  data_rd,
  input  rxstat_pkg::clr_mask_t cur_flags,
  output rxstat_pkg::clr_mask_t clr
);
  import rxstat_pkg::*;

  clr_mask_t armed_q;

  // a status read snapshots which flags it saw; a data read spends the snapshot
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        armed_q <= '0;
    else if (stat_rd)  armed_q <= cur_flags;
    else if (data_rd)  armed_q <= '0;
  end

  assign clr = data_rd ? armed_q : '0;

  assert_clear_after_data_rd_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (clr != '0) |-> data_rd);

endmodule

// File: rtl/rxstat_rdr.sv
module rxstat_rdr #(
  parameter int unsigned DATA_BITS = 8,
  localparam int unsigned DW = DATA_BITS + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          enable,
  input  logic          word_done,
  input  logic [DW-1:0] word_data,
  input  logic          noise_work,
  input  logic          frame_err,
  input  logic          clr_full,
  input  logic          clr_ovr,
  output logic          full_q,
  output logic          ovr_q,
  output logic          noise_q,
  output logic          frame_q,
  output logic [DW-1:0] data_q,
  output logic          load_evt,
  output logic          ovr_evt
);

  assign load_evt = enable && word_done && !full_q && !ovr_q;
  assign ovr_evt  = enable && word_done && (full_q || ovr_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      full_q  <= 1'b0;
      ovr_q   <= 1'b0;
      noise_q <= 1'b0;
      frame_q <= 1'b0;
      data_q  <= '0;
    end else begin
      if (load_evt) begin
        data_q  <= word_data;
        noise_q <= noise_work;
        frame_q <= frame_err;
        full_q  <= 1'b1;
      end else if (clr_full) begin
        full_q  <= 1'b0;
      end
      if (ovr_evt)      ovr_q <= 1'b1;
      else if (clr_ovr) ovr_q <= 1'b0;
    end
  end

  assert_load_sets_full_R2: assert property (@(posedge clk) disable iff (!rst_n)
    load_evt |=> full_q && data_q == $past(word_data));

  assert_overrun_keeps_data_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ovr_evt |=> ovr_q && $stable(data_q));

  assert_flags_with_load_R10: assert property (@(posedge clk) disable iff (!rst_n)
    load_evt |=> noise_q == $past(noise_work) && frame_q == $past(frame_err));

  assert_discard_keeps_noise_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ovr_evt |=> $stable(noise_q) && $stable(frame_q));

endmodule

// File: rtl/rxstat_ctrl.sv
module rxstat_ctrl #(
  parameter int unsigned DATA_BITS = 8,
  localparam int unsigned DW = DATA_BITS + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          rx_en,
  input  logic          nine_bit,
  input  logic          wake_hold,
  input  logic          word_done,
  input  logic [DW-1:0] word_data,
  input  logic          noise_work,
  input  logic          frame_err,
  input  logic          line_bit,
  input  logic          bit_tick,
  input  logic          stat_rd,
  input  logic          data_rd,
  output logic [7:0]    status_q,
  output logic [DW-1:0] data_q
);
  import rxstat_pkg::*;

  logic      full_w, ovr_w, noise_w, frame_w;
  logic      load_evt, ovr_evt, idle_evt;
  logic      idle_q, idle_armed_q;
  clr_mask_t cur_flags, clr;
  rx_flags_t flags;

  rxstat_rdr #(.DATA_BITS(DATA_BITS)) u_rdr (
    .clk       (clk),
    .rst_n     (rst_n),
    .enable    (rx_en),
    .word_done (word_done),
    .word_data (word_data),
    .noise_work(noise_work),
    .frame_err (frame_err),
    .clr_full  (clr.full),
    .clr_ovr   (clr.ovr),
    .full_q    (full_w),
    .ovr_q     (ovr_w),
    .noise_q   (noise_w),
    .frame_q   (frame_w),
    .data_q    (data_q),
    .load_evt  (load_evt),
    .ovr_evt   (ovr_evt)
  );

  rxstat_idle_det #(.DATA_BITS(DATA_BITS)) u_idle (
    .clk      (clk),
    .rst_n    (rst_n),
    .enable   (rx_en),
    .nine_bit (nine_bit),
    .line_bit (line_bit),
    .bit_tick (bit_tick),
    .idle_evt (idle_evt)
  );

  assign cur_flags = '{full: full_w, idle: idle_q, ovr: ovr_w};

  rxstat_clr_seq u_clr (
    .clk       (clk),
    .rst_n     (rst_n),
    .stat_rd   (stat_rd),
    .data_rd   (data_rd),
    .cur_flags (cur_flags),
    .clr       (clr)
  );

  // arming: a loaded word enables one idle event; disable or any event spends it
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         idle_armed_q <= 1'b0;
    else if (!rx_en)    idle_armed_q <= 1'b0;
    else if (load_evt)  idle_armed_q <= 1'b1;
    else if (idle_evt)  idle_armed_q <= 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                                     idle_q <= 1'b0;
    else if (idle_evt && idle_armed_q && !wake_hold) idle_q <= 1'b1;
    else if (clr.idle)                              idle_q <= 1'b0;
  end

  assign flags    = '{full: full_w, idle: idle_q, ovr: ovr_w, noise: noise_w, frame: frame_w};
  assign status_q = pack_status(flags);

  assert_idle_needs_arm_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(idle_q) |-> $past(idle_armed_q) && $past(idle_evt));

  assert_idle_not_in_wake_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(idle_q) |-> !$past(wake_hold));

  assert_full_falls_on_data_rd_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(status_q[5]) |-> $past(data_rd));

  assert_ovr_falls_on_data_rd_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(status_q[3]) |-> $past(data_rd));

  assert_status_spare_zero_R11: assert property (@(posedge clk) disable iff (!rst_n)
    status_q[7:6] == 2'b00 && status_q[0] == 1'b0);

endmodule

// File: tb/rxstat_ctrl_bench.sv
module rxstat_ctrl_bench;
  localparam int DW = 9;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          rx_en = 1'b1, nine_bit = 1'b0, wake_hold = 1'b0;
  logic          word_done = 1'b0, noise_work = 1'b0, frame_err = 1'b0;
  logic [DW-1:0] word_data = '0;
  logic          line_bit = 1'b1, bit_tick = 1'b0;
  logic          stat_rd = 1'b0, data_rd = 1'b0;
  logic [7:0]    status_q;
  logic [DW-1:0] data_q;

  int n_chk = 0;
  int n_bad = 0;

  always #2 clk = ~clk;

  rxstat_ctrl u_rxstat_ctrl (
    .clk(clk), .rst_n(rst_n), .rx_en(rx_en), .nine_bit(nine_bit),
    .wake_hold(wake_hold), .word_done(word_done), .word_data(word_data),
    .noise_work(noise_work), .frame_err(frame_err), .line_bit(line_bit),
    .bit_tick(bit_tick), .stat_rd(stat_rd), .data_rd(data_rd),
    .status_q(status_q), .data_q(data_q)
  );

  // status bits per R11
  localparam logic [7:0] S_FULL = 8'h20, S_IDLE = 8'h10, S_OVR = 8'h08,
                         S_NOISE = 8'h04, S_FRAME = 8'h02;

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic send_word(input logic [DW-1:0] d, input logic nz, input logic fe);
    @(negedge clk); word_data = d; noise_work = nz; frame_err = fe; word_done = 1'b1;
    @(negedge clk); word_done = 1'b0; noise_work = 1'b0; frame_err = 1'b0;
  endtask

  task automatic tick(input logic b);
    @(negedge clk); line_bit = b; bit_tick = 1'b1;
    @(negedge clk); bit_tick = 1'b0;
  endtask

  task automatic ticks_one(input int n);
    for (int i = 0; i < n; i++) tick(1'b1);
  endtask

  task automatic rd_stat();
    @(negedge clk); stat_rd = 1'b1;
    @(negedge clk); stat_rd = 1'b0;
  endtask

  task automatic rd_data();
    @(negedge clk); data_rd = 1'b1;
    @(negedge clk); data_rd = 1'b0;
  endtask

  task automatic clear_all();
    rd_stat(); rd_data();
  endtask

  task automatic t_reset();
    check("R1 status", {8'h0, status_q}, 16'h0);
    check("R1 data", {7'h0, data_q}, 16'h0);
    // R8: no word yet, a long run of ones must not set idle
    tick(1'b0); ticks_one(12);
    check("R8 idle before first word", {8'h0, status_q}, 16'h0);
  endtask

  task automatic t_load_clear();
    send_word(9'h05A, 1'b0, 1'b0);
    check("R2 full set", {8'h0, status_q}, {8'h0, S_FULL});
    check("R2 data", {7'h0, data_q}, 16'h005A);
    rd_data();
    check("R6 data read alone", {8'h0, status_q}, {8'h0, S_FULL});
    rd_stat(); rd_data();
    check("R5 full cleared", {8'h0, status_q}, 16'h0);
    check("R5 data kept", {7'h0, data_q}, 16'h005A);
  endtask

  task automatic t_stale_arm();
    rd_stat();
    send_word(9'h1C3, 1'b0, 1'b0);
    rd_data();
    check("R6 late flag survives", {8'h0, status_q}, {8'h0, S_FULL});
    check("R2 nine-bit data", {7'h0, data_q}, 16'h01C3);
    clear_all();
    check("R5 cleared after rearm", {8'h0, status_q}, 16'h0);
  endtask

  task automatic t_overrun();
    send_word(9'h011, 1'b0, 1'b0);
    send_word(9'h022, 1'b1, 1'b1);
    check("R3 overrun set", {8'h0, status_q}, {8'h0, S_FULL | S_OVR});
    check("R3 data kept", {7'h0, data_q}, 16'h0011);
    send_word(9'h033, 1'b1, 1'b0);
    check("R4 later word lost", {7'h0, data_q}, 16'h0011);
    check("R10 discard keeps noise", {8'h0, status_q}, {8'h0, S_FULL | S_OVR});
    clear_all();
    check("R5 overrun cleared", {8'h0, status_q}, 16'h0);
    send_word(9'h044, 1'b0, 1'b0);
    check("R4 next word loads", {7'h0, data_q}, 16'h0044);
    clear_all();
  endtask

  task automatic t_noise();
    send_word(9'h0F0, 1'b1, 1'b1);
    check("R10 noise frame full same edge", {8'h0, status_q},
          {8'h0, S_FULL | S_NOISE | S_FRAME});
    clear_all();
    check("R10 noise persists with data", {8'h0, status_q}, {8'h0, S_NOISE | S_FRAME});
    send_word(9'h00F, 1'b0, 1'b0);
    check("R10 clean word", {8'h0, status_q}, {8'h0, S_FULL});
    clear_all();
  endtask

  task automatic t_idle8();
    nine_bit = 1'b0;
    tick(1'b0); send_word(9'h055, 1'b0, 1'b0); clear_all();
    ticks_one(9);
    check("R7 nine ones no idle", {8'h0, status_q}, 16'h0);
    tick(1'b1);
    check("R7 ten ones idle", {8'h0, status_q}, {8'h0, S_IDLE});
    clear_all();
    check("R5 idle cleared", {8'h0, status_q}, 16'h0);
    tick(1'b0); ticks_one(12);
    check("R8 no rearm without word", {8'h0, status_q}, 16'h0);
  endtask

  task automatic t_idle9();
    nine_bit = 1'b1;
    tick(1'b0); send_word(9'h066, 1'b0, 1'b0); clear_all();
    ticks_one(5); tick(1'b0); ticks_one(10);
    check("R7 zero restarts run", {8'h0, status_q}, 16'h0);
    tick(1'b1);
    check("R7 eleven ones idle", {8'h0, status_q}, {8'h0, S_IDLE});
    clear_all();
    nine_bit = 1'b0;
  endtask

  task automatic t_wake();
    tick(1'b0); send_word(9'h077, 1'b0, 1'b0); clear_all();
    wake_hold = 1'b1;
    ticks_one(10);
    check("R9 wake idle ignored", {8'h0, status_q}, 16'h0);
    wake_hold = 1'b0;
    tick(1'b0); ticks_one(10);
    check("R9 arming spent by wake", {8'h0, status_q}, 16'h0);
  endtask

  task automatic t_enable();
    tick(1'b0); send_word(9'h088, 1'b0, 1'b0); clear_all();
    @(negedge clk); rx_en = 1'b0;
    @(negedge clk); rx_en = 1'b1;
    ticks_one(10);
    check("R8 reenable blocks idle", {8'h0, status_q}, 16'h0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_load_clear();
    t_stale_arm();
    t_overrun();
    t_noise();
    t_idle8();
    t_idle9();
    t_wake();
    t_enable();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=running expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
    $finish;
  end

endmodule